// File: doc/BRIEF.md
# Channel Sample Conditioner with Hit Detection

This block stands in a digitizer channel between the converter output and the per-channel sample FIFO. Each valid sample either passes through unchanged or, when the global test enable is high, is replaced by a pattern chosen by a three-bit mode field. Some patterns are synthetic: a fixed word, the time-bin index, the bin index packed with the channel number, or a running sample count. Others pack live status flags into the top bits of the real sample.

In parallel, a hit detector compares every valid sample against a threshold level. The level is either the absolute threshold or the baseline minus the threshold, and the subtraction clamps at zero. A sticky flag records whether any sample of the current event met the level. The flag is cleared by the event-start strobe, and its value is copied to a registered output on the event-end strobe. The output word is registered, so it appears one clock after its input sample.

Top module: `chan_sample_conditioner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_word and hit_out are all 0.
- R2: out_valid equals in_valid delayed by one clock; in a cycle after an invalid input, out_word keeps its previous value.
- R3: With test_en low, out_word is the input sample of the previous cycle, whatever the control word holds.
- R4: With test_en high, the mode field ctrl_word[14:12] selects the word. Mode 0 gives 0xA5A. Mode 7 gives the raw sample.
- R5: Mode 1 gives the time-bin index, zero-extended. Mode 2 gives {chan_idx[2:0], time_bin[8:0]}.
- R6: Mode 3 gives the number of valid samples seen earlier in the current event. The count restarts at 0 on a sample that arrives with evt_start, and it wraps at 12 bits.
- R7: Mode 4 gives {sticky crossed flag including the current sample, trig rising edge, trig falling edge, adc[8:0]}. An edge is judged against trig in the previous clock.
- R8: Mode 5 gives {trig, adc[10:0]}. Mode 6 gives {current-sample hit, adc[10:0]}.
- R9: With ctrl_word[15]=0, a valid sample is a hit when adc <= baseline - ctrl_word[11:0]. When the threshold exceeds the baseline, the level is 0 and no wrap occurs.
- R10: With ctrl_word[15]=1, a valid sample is a hit when adc <= ctrl_word[11:0].
- R11: The crossed flag is sticky within an event and cleared by evt_start. A hit on the evt_start sample counts for the new event. In the clock after evt_end, hit_out shows whether any sample of the event was a hit, including a sample in the evt_end cycle itself. At other times hit_out holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| adc | input | 12 | Input sample |
| ctrl_word | input | 16 | Threshold [11:0], test mode [14:12], absolute-threshold select [15] |
| baseline | input | 12 | Baseline level for the relative threshold |
| test_en | input | 1 | Global enable for pattern substitution |
| trig | input | 1 | Trigger level |
| evt_start | input | 1 | Event start strobe |
| evt_end | input | 1 | Event end strobe |
| time_bin | input | 9 | Time-bin index of the sample |
| chan_idx | input | 7 | Channel number |
| out_valid | output | 1 | Registered sample strobe |
| out_word | output | 12 | Registered selected word |
| hit_out | output | 1 | Event hit result, updated after evt_end |

## Verification
Two functions can fall in the same cycle: the event boundary strobes and the hit test. One case sends the only hitting sample of an event together with evt_end, so the reported flag must include it. Another case sends a hitting sample together with evt_start, so the flag must start the new event as set while the old value is dropped. The same boundary collision is provoked for the sample counter by raising evt_start with a valid sample, which must read 0. The scoreboard judges each case from its own model of the sticky flag and the counter.

// File: rtl/scond_pkg.sv
package scond_pkg;

    typedef enum logic [2:0] {
        PM_FIXED    = 3'd0,
        PM_BIN      = 3'd1,
        PM_BIN_CHAN = 3'd2,
        PM_COUNT    = 3'd3,
        PM_FLAGS3   = 3'd4,
        PM_TRIG     = 3'd5,
        PM_BELOW    = 3'd6,
        PM_RAW      = 3'd7
    } pat_mode_e;

    localparam logic [11:0] FIXED_WORD = 12'hA5A;

endpackage

// File: rtl/scond_hit_detect.sv
module scond_hit_detect #(
    parameter int SMP_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] adc,
    input  logic [SMP_W-1:0] baseline,
    input  logic [SMP_W-1:0] thr,
    input  logic             abs_mode,
    input  logic             evt_start,
    input  logic             evt_end,
    output logic             below_thr,
    output logic             crossed_run,
    output logic             hit_out
);

    typedef struct packed {
        logic crossed;
        logic hit_out;
    } hd_state_t;

    hd_state_t st_q, st_d;

    logic [SMP_W:0]   diff;
    logic [SMP_W-1:0] level;

    always_comb begin
        diff  = {1'b0, baseline} - {1'b0, thr};
        if (abs_mode) begin
            level = thr;
        end else if (diff[SMP_W]) begin
            level = '0;
        end else begin
            level = diff[SMP_W-1:0];
        end
        below_thr   = in_valid && (adc <= level);
        crossed_run = (evt_start ? 1'b0 : st_q.crossed) | below_thr;

        st_d         = st_q;
        st_d.crossed = crossed_run;
        if (evt_end) begin
            st_d.hit_out = crossed_run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_out = st_q.hit_out;

    // R11: flag stays set until the next event start
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.crossed && !evt_start) |=> st_q.crossed);

    // R11: event start without a hit leaves the flag clear
    a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_start && !below_thr) |=> !st_q.crossed);

    // R11: report holds between event ends
    a_r11_hold_report: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_end |=> $stable(hit_out));

    // R9: relative level never exceeds the baseline (no wrap)
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !abs_mode |-> (level <= baseline));

    // R10: absolute comparison reports a hit at the threshold itself
    a_r10_abs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_mode && in_valid && adc == thr) |-> below_thr);

endmodule

// File: rtl/scond_pattern_mux.sv
module scond_pattern_mux
    import scond_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int TB_W  = 9,
    parameter int CH_W  = 7
) (
    input  pat_mode_e        mode,
    input  logic [SMP_W-1:0] adc,
    input  logic [TB_W-1:0]  time_bin,
    input  logic [CH_W-1:0]  chan_idx,
    input  logic [SMP_W-1:0] sample_cnt,
    input  logic             crossed_run,
    input  logic             below_thr,
    input  logic             trig,
    input  logic             trig_rise,
    input  logic             trig_fall,
    output logic [SMP_W-1:0] word
);

    localparam int CAT_W = CH_W + TB_W;

    logic [CAT_W-1:0] bin_chan;

    always_comb begin
        bin_chan = {chan_idx, time_bin};
        unique case (mode)
            PM_FIXED:    word = SMP_W'(FIXED_WORD);
            PM_BIN:      word = SMP_W'(time_bin);
            PM_BIN_CHAN: word = SMP_W'(bin_chan);
            PM_COUNT:    word = sample_cnt;
            PM_FLAGS3:   word = {crossed_run, trig_rise, trig_fall, adc[SMP_W-4:0]};
            PM_TRIG:     word = {trig, adc[SMP_W-2:0]};
            PM_BELOW:    word = {below_thr, adc[SMP_W-2:0]};
            default:     word = adc;
        endcase
    end

endmodule

// File: rtl/chan_sample_conditioner.sv
module chan_sample_conditioner
    import scond_pkg::*;
#(
    parameter int SMP_W = 12,
    parameter int TB_W  = 9,
    parameter int CH_W  = 7,
    localparam int CTRL_W = SMP_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  adc,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [SMP_W-1:0]  baseline,
    input  logic              test_en,
    input  logic              trig,
    input  logic              evt_start,
    input  logic              evt_end,
    input  logic [TB_W-1:0]   time_bin,
    input  logic [CH_W-1:0]   chan_idx,
    output logic              out_valid,
    output logic [SMP_W-1:0]  out_word,
    output logic              hit_out
);

    localparam int MODE_LO = SMP_W;
    localparam int ABS_BIT = SMP_W + 3;

    typedef struct packed {
        logic             valid;
        logic [SMP_W-1:0] word;
        logic             trig_prev;
        logic [SMP_W-1:0] cnt;
    } top_state_t;

    top_state_t st_q, st_d;

    logic [SMP_W-1:0] thr;
    pat_mode_e        mode;
    logic             abs_mode;
    logic             below_thr, crossed_run;
    logic             trig_rise, trig_fall;
    logic [SMP_W-1:0] cnt_base;
    logic [SMP_W-1:0] pat_word;

    assign thr      = ctrl_word[SMP_W-1:0];
    assign mode     = pat_mode_e'(ctrl_word[MODE_LO+2:MODE_LO]);
    assign abs_mode = ctrl_word[ABS_BIT];

    scond_hit_detect #(.SMP_W(SMP_W)) u_hit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .adc        (adc),
        .baseline   (baseline),
        .thr        (thr),
        .abs_mode   (abs_mode),
        .evt_start  (evt_start),
        .evt_end    (evt_end),
        .below_thr  (below_thr),
        .crossed_run(crossed_run),
        .hit_out    (hit_out)
    );

    scond_pattern_mux #(.SMP_W(SMP_W), .TB_W(TB_W), .CH_W(CH_W)) u_mux (
        .mode       (mode),
        .adc        (adc),
        .time_bin   (time_bin),
        .chan_idx   (chan_idx),
        .sample_cnt (cnt_base),
        .crossed_run(crossed_run),
        .below_thr  (below_thr),
        .trig       (trig),
        .trig_rise  (trig_rise),
        .trig_fall  (trig_fall),
        .word       (pat_word)
    );

    always_comb begin
        trig_rise = trig & ~st_q.trig_prev;
        trig_fall = ~trig & st_q.trig_prev;
        cnt_base  = evt_start ? '0 : st_q.cnt;

        st_d           = st_q;
        st_d.valid     = in_valid;
        st_d.trig_prev = trig;
        st_d.cnt       = cnt_base + SMP_W'(in_valid);
        if (in_valid) begin
            st_d.word = test_en ? pat_word : adc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;

    // R2: one-cycle latency on the strobe
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: word holds after an idle input
    a_r2_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R3: bypass when substitution is off
    a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !test_en) |=> (out_word == $past(adc)));

    // R4: fixed pattern
    a_r4_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && test_en && mode == PM_FIXED) |=> (out_word == SMP_W'(FIXED_WORD)));

    // R6: counter advances by one per valid sample inside an event
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !evt_start) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: tb/chan_sample_conditioner_test.sv
module chan_sample_conditioner_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] adc = '0;
    logic [15:0] ctrl_word = '0;
    logic [11:0] baseline = '0;
    logic        test_en = 1'b0;
    logic        trig = 1'b0;
    logic        evt_start = 1'b0;
    logic        evt_end = 1'b0;
    logic [8:0]  time_bin = '0;
    logic [6:0]  chan_idx = '0;
    logic        out_valid;
    logic [11:0] out_word;
    logic        hit_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    chan_sample_conditioner uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .adc(adc),
        .ctrl_word(ctrl_word), .baseline(baseline), .test_en(test_en),
        .trig(trig), .evt_start(evt_start), .evt_end(evt_end),
        .time_bin(time_bin), .chan_idx(chan_idx),
        .out_valid(out_valid), .out_word(out_word), .hit_out(hit_out)
    );

    // scoreboard queues
    bit          q_v[$];
    logic [11:0] q_w[$];
    string       q_tag[$];
    bit          hq_v[$];
    string       hq_tag[$];

    // reference model state
    bit          m_crossed = 0;
    logic [11:0] m_cnt = '0;
    bit          m_tprev = 0;
    logic [11:0] m_last = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [11:0] a, input logic [15:0] cw,
                         input logic [11:0] bl, input bit ten, input bit tg,
                         input bit es, input bit ee, input logic [8:0] tb,
                         input logic [6:0] ch, input string tag);
        logic [11:0] thr, level, base_cnt, w;
        bit hit, run, rise, fall;
        @(negedge clk);
        #1;
        in_valid = v; adc = a; ctrl_word = cw; baseline = bl; test_en = ten;
        trig = tg; evt_start = es; evt_end = ee; time_bin = tb; chan_idx = ch;
        thr = cw[11:0];
        if (cw[15])        level = thr;
        else if (thr > bl) level = 12'd0;
        else               level = bl - thr;
        hit  = v && (a <= level);
        run  = (es ? 1'b0 : m_crossed) | hit;
        rise = tg && !m_tprev;
        fall = !tg && m_tprev;
        base_cnt = es ? 12'd0 : m_cnt;
        if (!ten) w = a;
        else begin
            case (cw[14:12])
                3'd0: w = 12'hA5A;
                3'd1: w = {3'b000, tb};
                3'd2: w = {ch[2:0], tb};
                3'd3: w = base_cnt;
                3'd4: w = {run, rise, fall, a[8:0]};
                3'd5: w = {tg, a[10:0]};
                3'd6: w = {hit, a[10:0]};
                default: w = a;
            endcase
        end
        if (v) m_last = w;
        q_v.push_back(v); q_w.push_back(m_last); q_tag.push_back(tag);
        if (ee) begin
            hq_v.push_back(run); hq_tag.push_back(tag);
        end
        m_crossed = run;
        m_cnt     = base_cnt + (v ? 12'd1 : 12'd0);
        m_tprev   = tg;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && q_v.size() > 0) begin
                bit ev; logic [11:0] ew; string t;
                ev = q_v.pop_front(); ew = q_w.pop_front(); t = q_tag.pop_front();
                check(out_valid == ev, t, "out_valid", int'(out_valid), int'(ev));
                check(out_word == ew, t, "out_word", int'(out_word), int'(ew));
            end
            if (rst_n && hq_v.size() > 0) begin
                bit eh; string t;
                eh = hq_v.pop_front(); t = hq_tag.pop_front();
                check(hit_out == eh, t, "hit_out", int'(hit_out), int'(eh));
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [15:0] M0 = 16'h0000, M1 = 16'h1000, M2 = 16'h2000,
                            M3 = 16'h3000, M4 = 16'h4000, M5 = 16'h5000,
                            M6 = 16'h6000, M7 = 16'h7000;

    initial begin
        // R1: reset state
        in_valid = 1'b1; adc = 12'hFFF;
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
        check(out_word == 0, "R1", "out_word", int'(out_word), 0);
        check(hit_out == 0, "R1", "hit_out", int'(hit_out), 0);
        in_valid = 1'b0; adc = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 0 && out_word == 0 && hit_out == 0, "R1", "first cycle",
              int'({out_valid, out_word, hit_out}), 0);

        // R3 / R2: bypass with idle gaps, control word ignored
        drive(1, 12'h123, M0, 12'h800, 0, 0, 0, 0, 9'd0, 7'd0, "R3");
        drive(0, 12'hEEE, M0, 12'h800, 0, 0, 0, 0, 9'd0, 7'd0, "R2");
        drive(1, 12'hFED, M5, 12'h800, 0, 0, 0, 0, 9'd0, 7'd0, "R3");
        drive(0, 12'h000, M5, 12'h800, 0, 0, 0, 0, 9'd0, 7'd0, "R2");
        drive(0, 12'h555, M5, 12'h800, 0, 0, 0, 0, 9'd0, 7'd0, "R2");

        // R4: fixed and raw codes
        drive(1, 12'h321, M0, 12'h800, 1, 0, 0, 0, 9'd0, 7'd0, "R4");
        drive(1, 12'h9C3, M7, 12'h800, 1, 0, 0, 0, 9'd0, 7'd0, "R4");

        // R5: time bin and channel packing
        drive(1, 12'h000, M1, 12'h800, 1, 0, 0, 0, 9'h1A5, 7'h55, "R5");
        drive(1, 12'h000, M2, 12'h800, 1, 0, 0, 0, 9'h1A5, 7'h55, "R5");
        drive(1, 12'h000, M2, 12'h800, 1, 0, 0, 0, 9'h0F0, 7'h02, "R5");

        // R6: sample counter, restart with evt_start, gap in the middle
        drive(1, 12'h010, M3, 12'h800, 1, 0, 1, 0, 9'd0, 7'd0, "R6");
        drive(1, 12'h011, M3, 12'h800, 1, 0, 0, 0, 9'd1, 7'd0, "R6");
        drive(0, 12'h012, M3, 12'h800, 1, 0, 0, 0, 9'd2, 7'd0, "R6");
        drive(1, 12'h013, M3, 12'h800, 1, 0, 0, 0, 9'd3, 7'd0, "R6");
        drive(1, 12'h014, M3, 12'h800, 1, 0, 1, 0, 9'd0, 7'd0, "R6");
        drive(1, 12'h015, M3, 12'h800, 1, 0, 0, 0, 9'd1, 7'd0, "R6");

        // R7: flag packing, trigger edges, sticky crossed (baseline 0x800, thr 0x100 -> level 0x700)
        drive(1, 12'hF12, M4 | 16'h0100, 12'h800, 1, 0, 1, 0, 9'd0, 7'd0, "R7");
        drive(1, 12'hF34, M4 | 16'h0100, 12'h800, 1, 1, 0, 0, 9'd0, 7'd0, "R7");
        drive(1, 12'h600, M4 | 16'h0100, 12'h800, 1, 1, 0, 0, 9'd0, 7'd0, "R7");
        drive(1, 12'hF56, M4 | 16'h0100, 12'h800, 1, 0, 0, 0, 9'd0, 7'd0, "R7");
        drive(1, 12'hF78, M4 | 16'h0100, 12'h800, 1, 0, 0, 1, 9'd0, 7'd0, "R11");

        // R8: trigger and below-threshold packing
        drive(1, 12'hABC, M5, 12'h800, 1, 1, 0, 0, 9'd0, 7'd0, "R8");
        drive(1, 12'hABC, M5, 12'h800, 1, 0, 0, 0, 9'd0, 7'd0, "R8");
        drive(1, 12'h7FF, M6 | 16'h8400, 12'h800, 1, 0, 0, 0, 9'd0, 7'd0, "R8");

        // R9: relative level, boundary at 0x700
        drive(1, 12'h701, M6 | 16'h0100, 12'h800, 1, 0, 1, 0, 9'd0, 7'd0, "R9");
        drive(1, 12'h702, M6 | 16'h0100, 12'h800, 1, 0, 0, 1, 9'd0, 7'd0, "R9");
        drive(1, 12'h700, M6 | 16'h0100, 12'h800, 1, 0, 1, 0, 9'd0, 7'd0, "R9");
        drive(1, 12'h900, M6 | 16'h0100, 12'h800, 1, 0, 0, 1, 9'd0, 7'd0, "R9");
        // R9: saturation, thr above baseline -> level 0
        drive(1, 12'h001, M6 | 16'h0100, 12'h050, 1, 0, 1, 0, 9'd0, 7'd0, "R9");
        drive(1, 12'hFFF, M6 | 16'h0100, 12'h050, 1, 0, 0, 1, 9'd0, 7'd0, "R9");
        drive(1, 12'h000, M6 | 16'h0100, 12'h050, 1, 0, 1, 1, 9'd0, 7'd0, "R9");

        // R10: absolute threshold 0x300 (bit 15 set), baseline ignored
        drive(1, 12'h301, M6 | 16'h8300, 12'hFFF, 1, 0, 1, 0, 9'd0, 7'd0, "R10");
        drive(1, 12'h300, M6 | 16'h8300, 12'h000, 1, 0, 0, 1, 9'd0, 7'd0, "R10");
        drive(1, 12'h301, M6 | 16'h8300, 12'h000, 1, 0, 1, 1, 9'd0, 7'd0, "R10");

        // R11: hit only on evt_end sample, hit on evt_start sample, sticky via idle
        drive(1, 12'hF00, M6 | 16'h8300, 12'h0, 1, 0, 1, 0, 9'd0, 7'd0, "R11");
        drive(1, 12'h100, M6 | 16'h8300, 12'h0, 1, 0, 0, 1, 9'd0, 7'd0, "R11");
        drive(1, 12'h100, M6 | 16'h8300, 12'h0, 1, 0, 1, 0, 9'd0, 7'd0, "R11");
        drive(0, 12'h000, M6 | 16'h8300, 12'h0, 1, 0, 0, 0, 9'd0, 7'd0, "R11");
        drive(1, 12'hF00, M6 | 16'h8300, 12'h0, 1, 0, 0, 1, 9'd0, 7'd0, "R11");
        drive(1, 12'h100, M6 | 16'h8300, 12'h0, 1, 0, 0, 0, 9'd0, 7'd0, "R11");
        drive(1, 12'hF00, M6 | 16'h8300, 12'h0, 1, 0, 1, 1, 9'd0, 7'd0, "R11");

        drive(0, 12'h000, M0, 12'h0, 0, 0, 0, 0, 9'd0, 7'd0, "R2");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule